// File: doc/BRIEF.md
# Good-Data Receive FIFO Filter

This block sits between a serial receiver and the host side of a receive queue. Every byte that arrives carries three error indications: parity, framing and break. The block stores the byte together with one flag that marks it as errored. It also keeps a running count of how many entries at the head of the queue are clean, so the host can drain that many bytes without checking status after each one. When the first errored entry reaches the head and is read out, the count is rebuilt from the entries that follow it.

Two mode inputs control this. The first, good-data mode, makes the clean-run length visible in the length register and enables the good-data interrupt. When a second, stricter input is also set, errored bytes are discarded at the input and never take a queue slot. An interrupt encoder gives the host one identification code with a fixed priority: line status first, then good data, then plain data available. Baud generation and bit sampling are handled upstream.

Top module: `gd_rx_filter`

## Requirements
- R1: After a synchronous active-low reset, the queue is empty, `gdl` is 0x00, `lsr_rx_err` and `overrun` are 0, `irq` is 0 and `irq_id` is 0x01.
- R2: A byte is stored as errored when any of `rx_par_err`, `rx_frm_err` or `rx_brk` is high with `rx_valid`. Bytes leave in arrival order. `rd_data` and `rd_err` show the head entry before it is read.
- R3: With `gd_mode_en` high, `gdl[6:0]` holds the number of consecutive clean entries counted from the head, capped at 127. With `gd_mode_en` low, `gdl` reads 0x00.
- R4: `lsr_rx_err` is 1 while at least one errored entry is in the queue, in either mode. With `gd_mode_en` high, `gdl[7]` equals `lsr_rx_err`.
- R5: Reading an errored head entry sets the clean count, one cycle later, to the run of clean entries that follow it up to the next errored entry.
- R6: When `gd_mode_en` and `gd_only_en` are both high, an errored byte is discarded and changes nothing. With `gd_mode_en` low, `gd_only_en` has no effect.
- R7: A byte that arrives while the queue holds DEPTH entries (default 128) is lost and sets `overrun`. The next read that removes an entry clears `overrun`.
- R8: `irq_id` is 0x06 when `ier_ls_en` is set and either `overrun` is set or the head is errored. Otherwise it is 0x1C when good-data mode and `ier_gd_en` are set and the clean count is non-zero. Otherwise it is 0x04 when good-data mode is off, `ier_rda_en` is set and the queue is not empty. Otherwise it is 0x01. `irq` is 1 exactly when `irq_id` is not 0x01.
- R9: A read strobe while the queue is empty changes nothing.
- R10: A write and a read in the same cycle both take effect. The clean count then includes the new byte when it extends the clean run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Received-byte strobe |
| rx_data | input | 8 | Received byte |
| rx_par_err | input | 1 | Parity error on this byte |
| rx_frm_err | input | 1 | Framing error on this byte |
| rx_brk | input | 1 | Break condition on this byte |
| rd_en | input | 1 | Host read strobe, removes the head entry |
| gd_mode_en | input | 1 | Good-data mode |
| gd_only_en | input | 1 | Discard errored bytes (effective only in good-data mode) |
| ier_rda_en | input | 1 | Enable data-available interrupt |
| ier_ls_en | input | 1 | Enable line-status interrupt |
| ier_gd_en | input | 1 | Enable good-data interrupt |
| rd_data | output | 8 | Head byte |
| rd_err | output | 1 | Head entry is errored |
| rd_empty | output | 1 | Queue is empty |
| gdl | output | 8 | Bit 7 errored entry present, bits 6:0 clean count |
| lsr_rx_err | output | 1 | Errored entry somewhere in the queue |
| overrun | output | 1 | Byte lost because the queue was full |
| irq | output | 1 | Interrupt request |
| irq_id | output | 8 | Interrupt identification code |

## Verification
A clean count that drifts from the stored error flags shows up in `gdl` one cycle after the write or read that causes it. It also breaks the link between a non-zero count and a clean head, which is visible on `rd_err` right away. A wrong rebuild after an errored head is read becomes visible on the next cycle and again on each later read, because each read should lower the count by one. An error counter that is out of step keeps `lsr_rx_err` high after the last errored byte has left, or lets it drop too early. Both show at the ports as soon as the queue drains.

// File: rtl/gd_rx_pkg.sv
package gd_rx_pkg;
    // Error indications that travel with a received byte
    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rx_err_t;

    // Interrupt identification codes
    localparam logic [7:0] IID_NONE = 8'h01;
    localparam logic [7:0] IID_RDA  = 8'h04;
    localparam logic [7:0] IID_LS   = 8'h06;
    localparam logic [7:0] IID_GD   = 8'h1C;
endpackage

// File: rtl/gd_fifo_store.sv
// Circular byte queue with one error tag per entry.
// Shows the head entry before it is read, and gives every entry's tag
// rotated so that index 0 is the head. DEPTH must be a power of two.
// The caller never pushes when full and never pops when empty.
module gd_fifo_store #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int OW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [DW-1:0]    wdata,
    input  logic             werr,
    output logic [DW-1:0]    rdata,
    output logic             rerr,
    output logic [OW-1:0]    occ,
    output logic [DEPTH-1:0] err_rot
);
    logic [DW-1:0]    mem_d [DEPTH];
    logic [DEPTH-1:0] mem_e;
    logic [AW-1:0]    wp, rp;

    // Store the byte and its tag at the write pointer
    always_ff @(posedge clk) begin
        if (push) begin
            mem_d[wp] <= wdata;
            mem_e[wp] <= werr;
        end
    end

    // Advance the pointers and track occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            occ <= '0;
        end else begin
            if (push) wp <= wp + AW'(1);
            if (pop)  rp <= rp + AW'(1);
            occ <= occ + OW'(push) - OW'(pop);
        end
    end

    assign rdata = mem_d[rp];
    assign rerr  = mem_e[rp];

    // Tags seen from the head: bit i belongs to the i-th entry after the head
    for (genvar i = 0; i < DEPTH; i++) begin : g_rot
        assign err_rot[i] = mem_e[rp + AW'(i)];
    end
endmodule

// File: rtl/gd_run_scan.sv
// Finds the first errored entry after the head, counted in positions from
// the head. Returns occ when no such entry exists among the valid ones.
// Used to rebuild the clean count after an errored head is read.
module gd_run_scan #(
    parameter int DEPTH = 128,
    localparam int OW   = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0] err_rot,
    input  logic [OW-1:0]    occ,
    output logic [OW-1:0]    first_bad
);
    // Priority search from the far end so the nearest errored entry wins
    always_comb begin
        first_bad = occ;
        for (int j = DEPTH - 1; j >= 1; j--) begin
            if ((OW'(j) < occ) && err_rot[j]) first_bad = OW'(j);
        end
    end
endmodule

// File: rtl/gd_irq_enc.sv
// Turns the three pending conditions into one identification code with a
// fixed priority: line status, then good data, then data available.
module gd_irq_enc
    import gd_rx_pkg::*;
(
    input  logic       ls_pend,
    input  logic       gd_pend,
    input  logic       rda_pend,
    output logic       irq,
    output logic [7:0] irq_id
);
    // Select the highest-priority pending source
    always_comb begin
        if (ls_pend)       irq_id = IID_LS;
        else if (gd_pend)  irq_id = IID_GD;
        else if (rda_pend) irq_id = IID_RDA;
        else               irq_id = IID_NONE;
    end

    assign irq = ls_pend | gd_pend | rda_pend;
endmodule

// File: rtl/gd_rx_filter.sv
// Good-data receive filter: tags received bytes with an error flag, queues
// them, and keeps the length of the clean run at the head of the queue.
// The run is updated step by step on writes and reads. It is rebuilt by a
// search only when an errored head leaves. Assumes DEPTH is a power of two.
module gd_rx_filter
    import gd_rx_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int CNT_W = 7,
    localparam int OW   = $clog2(DEPTH + 1),
    localparam int CAP  = (1 << CNT_W) - 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_par_err,
    input  logic       rx_frm_err,
    input  logic       rx_brk,
    input  logic       rd_en,
    input  logic       gd_mode_en,
    input  logic       gd_only_en,
    input  logic       ier_rda_en,
    input  logic       ier_ls_en,
    input  logic       ier_gd_en,
    output logic [7:0] rd_data,
    output logic       rd_err,
    output logic       rd_empty,
    output logic [7:0] gdl,
    output logic       lsr_rx_err,
    output logic       overrun,
    output logic [7:0] irq_id,
    output logic       irq
);
    rx_err_t          flags;
    logic             any_err, drop, full, push, pop, push_good, head_bad;
    logic [OW-1:0]    occ, first_bad, run, run_n, bad_cnt;
    logic [DEPTH-1:0] err_rot;

    assign flags     = '{brk: rx_brk, frm: rx_frm_err, par: rx_par_err};
    assign any_err   = |flags;
    assign drop      = rx_valid & any_err & gd_mode_en & gd_only_en;
    assign full      = (occ == OW'(DEPTH));
    assign push      = rx_valid & ~drop & ~full;
    assign pop       = rd_en & (occ != '0);
    assign push_good = push & ~any_err;
    assign head_bad  = pop & rd_err;
    assign rd_empty  = (occ == '0);

    gd_fifo_store #(.DEPTH(DEPTH), .DW(8)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .wdata(rx_data), .werr(any_err), .rdata(rd_data), .rerr(rd_err),
        .occ(occ), .err_rot(err_rot)
    );

    gd_run_scan #(.DEPTH(DEPTH)) u_scan (
        .err_rot(err_rot), .occ(occ), .first_bad(first_bad)
    );

    // Next clean-run length for this cycle's write and read
    always_comb begin
        if (head_bad)
            run_n = first_bad - OW'(1) + OW'(push_good && (first_bad == occ));
        else if (pop)
            run_n = run - OW'(1) + OW'(push_good && (bad_cnt == '0));
        else
            run_n = run + OW'(push_good && (bad_cnt == '0));
    end

    // Register the clean run and the count of errored entries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= '0;
            bad_cnt <= '0;
        end else begin
            run     <= run_n;
            bad_cnt <= bad_cnt + OW'(push & any_err) - OW'(head_bad);
        end
    end

    // Sticky overrun: set by a lost byte, cleared by a read that removes one
    always_ff @(posedge clk) begin
        if (!rst_n)                     overrun <= 1'b0;
        else if (rx_valid & ~drop & full) overrun <= 1'b1;
        else if (pop)                   overrun <= 1'b0;
    end

    assign lsr_rx_err = (bad_cnt != '0);
    assign gdl = gd_mode_en
               ? {lsr_rx_err, (run > OW'(CAP)) ? CNT_W'(CAP) : run[CNT_W-1:0]}
               : 8'h00;

    gd_irq_enc u_irq (
        .ls_pend (ier_ls_en & (overrun | (~rd_empty & rd_err))),
        .gd_pend (gd_mode_en & ier_gd_en & (run != '0)),
        .rda_pend(~gd_mode_en & ier_rda_en & ~rd_empty),
        .irq     (irq),
        .irq_id  (irq_id)
    );
endmodule

// File: rtl/gd_rx_filter_chk.sv
// Port-level properties of the good-data filter, attached by bind.
module gd_rx_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       rx_par_err,
    input logic       rx_frm_err,
    input logic       rx_brk,
    input logic       rd_en,
    input logic       gd_mode_en,
    input logic       gd_only_en,
    input logic       rd_err,
    input logic       rd_empty,
    input logic [7:0] gdl,
    input logic       lsr_rx_err,
    input logic       overrun,
    input logic       irq,
    input logic [7:0] irq_id
);
    // R2
    head_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gd_mode_en && gdl[6:0] != 7'd0) |-> (!rd_err && !rd_empty));

    // R4
    err_flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gd_mode_en |-> (gdl[7] == lsr_rx_err));

    // R4
    err_flag_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !rx_valid) |=> $stable(lsr_rx_err));

    // R6
    no_errored_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gd_mode_en && gd_only_en && rx_valid && (rx_par_err || rx_frm_err || rx_brk)
         && rd_empty) |=> rd_empty);

    // R7
    overrun_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(rx_valid));

    // R8
    irq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (irq_id != 8'h01));

    // R9
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_empty && !rx_valid) |=> rd_empty);
endmodule

bind gd_rx_filter gd_rx_filter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_par_err(rx_par_err),
    .rx_frm_err(rx_frm_err), .rx_brk(rx_brk), .rd_en(rd_en),
    .gd_mode_en(gd_mode_en), .gd_only_en(gd_only_en), .rd_err(rd_err),
    .rd_empty(rd_empty), .gdl(gdl), .lsr_rx_err(lsr_rx_err),
    .overrun(overrun), .irq(irq), .irq_id(irq_id)
);

// File: tb/sim_gd_rx_filter.sv
`timescale 1ns/1ps
module sim_gd_rx_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 0, rx_par_err = 0, rx_frm_err = 0, rx_brk = 0, rd_en = 0;
    logic [7:0] rx_data = 8'h00;
    logic       gd_mode_en = 0, gd_only_en = 0, ier_rda_en = 0, ier_ls_en = 0, ier_gd_en = 0;
    logic [7:0] rd_data, gdl, irq_id;
    logic       rd_err, rd_empty, lsr_rx_err, overrun, irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gd_rx_filter u0 (.*);

    // {push=1/pop=0, data, err {brk,frm,par}, expected gdl}; pops give head data and tag
    localparam logic [19:0] VEC [12] = '{
        {1'b1, 8'hA1, 3'b000, 8'h01}, {1'b1, 8'hA2, 3'b000, 8'h02},
        {1'b1, 8'hA3, 3'b001, 8'h82}, {1'b1, 8'hA4, 3'b000, 8'h82},
        {1'b1, 8'hA5, 3'b000, 8'h82}, {1'b0, 8'hA1, 3'b000, 8'h81},
        {1'b0, 8'hA2, 3'b000, 8'h80}, {1'b0, 8'hA3, 3'b001, 8'h02},
        {1'b1, 8'hA6, 3'b010, 8'h82}, {1'b0, 8'hA4, 3'b000, 8'h81},
        {1'b0, 8'hA5, 3'b000, 8'h80}, {1'b0, 8'hA6, 3'b010, 8'h00}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input bit wr, input logic [7:0] d, input logic [2:0] e, input bit rd);
        rx_valid = wr; rx_data = d; {rx_brk, rx_frm_err, rx_par_err} = e; rd_en = rd;
        @(negedge clk);
        rx_valid = 0; rd_en = 0; {rx_brk, rx_frm_err, rx_par_err} = 3'b000;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(rd_empty && gdl == 8'h00 && !lsr_rx_err && !overrun, "R1", gdl, 0);
        check(!irq && irq_id == 8'h01, "R1 irq", irq_id, 8'h01);

        // Table walk in good-data mode
        gd_mode_en = 1;
        for (int i = 0; i < 12; i++) begin
            logic [19:0] v;
            v = VEC[i];
            if (!v[19]) begin
                check(rd_data == v[18:11], "R2 order", rd_data, v[18:11]);
                check(rd_err == (v[10:8] != 0), "R2 tag", rd_err, v[10:8] != 0);
            end
            cyc(v[19], v[18:11], v[10:8], !v[19]);
            check(gdl == v[7:0], (i == 7) ? "R5 rebuild" : "R3 count", gdl, v[7:0]);
            check(lsr_rx_err == v[7], "R4", lsr_rx_err, v[7]);
        end

        // R9 read on empty
        cyc(0, 0, 0, 1);
        check(rd_empty && gdl == 8'h00, "R9", gdl, 0);
        cyc(1, 8'h3C, 0, 0);
        check(rd_data == 8'h3C && gdl == 8'h01, "R9 ptr", rd_data, 8'h3C);

        // R10 write and read together, clean head
        cyc(1, 8'h3D, 0, 1);
        check(gdl == 8'h01 && rd_data == 8'h3D, "R10 clean", gdl, 8'h01);
        cyc(0, 0, 0, 1);
        // R10 errored head leaves while a clean byte enters
        cyc(1, 8'h40, 3'b100, 0);
        cyc(1, 8'h41, 0, 1);
        check(gdl == 8'h01 && !lsr_rx_err && rd_data == 8'h41, "R10 bad head", gdl, 8'h01);
        cyc(0, 0, 0, 1);

        // R6 discard in strict mode
        gd_only_en = 1;
        cyc(1, 8'h50, 3'b100, 0);
        check(rd_empty && !lsr_rx_err, "R6 drop", rd_empty, 1);
        cyc(1, 8'h51, 0, 0);
        check(gdl == 8'h01 && rd_data == 8'h51, "R6 keep", gdl, 8'h01);
        cyc(0, 0, 0, 1);
        // R6 no effect without good-data mode; R3 gdl reads zero
        gd_mode_en = 0;
        cyc(1, 8'h52, 3'b010, 0);
        check(!rd_empty && rd_err && lsr_rx_err, "R6 off", rd_err, 1);
        check(gdl == 8'h00, "R3 off", gdl, 0);
        cyc(0, 0, 0, 1);
        gd_only_en = 0;

        // R8 interrupt codes
        ier_rda_en = 1; ier_ls_en = 1; ier_gd_en = 1;
        @(negedge clk);
        check(irq_id == 8'h01 && !irq, "R8 none", irq_id, 8'h01);
        cyc(1, 8'h60, 0, 0);
        check(irq_id == 8'h04 && irq, "R8 rda", irq_id, 8'h04);
        gd_mode_en = 1;
        @(negedge clk);
        check(irq_id == 8'h1C, "R8 gd", irq_id, 8'h1C);
        cyc(1, 8'h61, 3'b001, 0);
        cyc(0, 0, 0, 1);
        check(irq_id == 8'h06, "R8 ls", irq_id, 8'h06);
        ier_ls_en = 0;
        @(negedge clk);
        check(irq_id == 8'h01 && !irq, "R8 masked", irq_id, 8'h01);
        cyc(0, 0, 0, 1);
        ier_rda_en = 0; ier_gd_en = 0;

        // R3 cap and R7 overrun
        for (int i = 0; i < 128; i++) cyc(1, 8'(i), 0, 0);
        check(gdl == 8'h7F && !overrun, "R3 cap", gdl, 8'h7F);
        cyc(1, 8'hEE, 0, 0);
        check(overrun, "R7 set", overrun, 1);
        check(rd_data == 8'h00, "R7 head", rd_data, 0);
        cyc(0, 0, 0, 1);
        check(!overrun && gdl == 8'h7F, "R7 clear", overrun, 0);
        cyc(0, 0, 0, 1);
        check(gdl == 8'h7E, "R3 below cap", gdl, 8'h7E);
        for (int i = 2; i < 128; i++) begin
            check(rd_data == 8'(i), "R7 data", rd_data, i);
            cyc(0, 0, 0, 1);
        end
        check(rd_empty && gdl == 8'h00, "R7 lost byte", rd_data, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule